// File: doc/BRIEF.md
# Indexed Configuration Port with SMI Status

This block is a chipset configuration register file reached through two addresses on an 8-bit I/O bus. A write to the index address selects one of 256 byte registers. The data address then reads or writes that register. Reads of any address other than the data address return all ones.

Some register writes have side effects for power management. Writing the software-SMI register with its top bit set marks a status flag and, if the SMI enable register allows it, raises an SMI request level. The request stays high until an acknowledge input clears it. Two status bytes sit behind a single index: a bank bit written to that index picks which byte a later read returns, and the read clears that byte. The block also drives the ISA clock selection (a PCI-clock divider, or a fixed-rate source) and an enable for an extra SMRAM window. That window maps 128 KiB at A0000h onto DRAM at 40000h.

A build parameter selects the basic variant. In that variant the upper register range, from 60h, drops all writes, and so none of its side effects can occur.

Top module: `cfg_index_port`

## Requirements
- R1: A write to I/O address 22h loads the index. A read or write at I/O address 23h then reaches the byte register the index selects, and stored bytes read back unchanged.
- R2: A read at any I/O address other than 23h, including 22h, returns FFh.
- R3: With EXTENDED=0, writes through 23h to any index of 60h or above are dropped. Such registers read 00h, and no side effect (SMI, status, SMRAM window) occurs.
- R4: Writing index 64h with bit 7 set sets bit 4 of status byte 0. If bit 7 of register 65h is set at that moment, smi_req goes high on the same clock edge. Writing 64h with bit 7 clear changes nothing.
- R5: Writing index 6Ah stores bit 7 as the bank select (0 selects status byte 0, 1 selects status byte 1). A read of 6Ah returns the selected status byte and clears it to 00h, and leaves the other byte alone.
- R6: smi_req stays high until a cycle with smi_ack high clears it. A trigger in the same cycle as an acknowledge leaves smi_req high.
- R7: One cycle after register 10h changes, isa_div shows the divider its bits 1:0 select: 00 gives 4, 01 gives 6, 10 gives 8, and 11 (reserved) gives 4.
- R8: One cycle after register 1Ch changes, isa_fixed_clk equals its bit 1. A value of 1 selects the fixed-rate ISA clock in place of the divided PCI clock.
- R9: smram_win_en equals bit 2 of register 70h in the extended variant.
- R10: After reset the index, every register and both status bytes are 00h, smi_req is 0, isa_div is 4 and isa_fixed_clk is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address of the current cycle |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | DW | Write data |
| io_rdata | output | DW | Read data, valid while io_rd is high |
| smi_ack | input | 1 | Clears the SMI request |
| smi_req | output | 1 | SMI request level |
| isa_div | output | 4 | Selected PCI-to-ISA clock divider |
| isa_fixed_clk | output | 1 | Fixed-rate ISA clock selected |
| smram_win_en | output | 1 | Optional SMRAM window enabled |

## Verification
The assertions assume that io_rd and io_wr are never high in the same cycle. That matters because the status clear on a read and the flag set on a trigger write are only ordered under that assumption. The tasks drive each access as a single one-cycle strobe, changed only on the falling edge. Both variants run side by side on the same bus, so each dropped write in the basic variant is compared against its effect in the extended one.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    // Bus addresses of the two ports
    localparam logic [7:0] PORT_INDEX = 8'h22;
    localparam logic [7:0] PORT_DATA  = 8'h23;

    // First index of the upper (extended-only) register range
    localparam logic [7:0] EXT_FIRST  = 8'h60;

    // Register indices with side effects
    localparam logic [7:0] IDX_CLKDIV = 8'h10;
    localparam logic [7:0] IDX_CLKSRC = 8'h1C;
    localparam logic [7:0] IDX_SWSMI  = 8'h64;
    localparam logic [7:0] IDX_SMIEN  = 8'h65;
    localparam logic [7:0] IDX_STATUS = 8'h6A;
    localparam logic [7:0] IDX_SMRAM  = 8'h70;

    // Bit positions inside those registers
    localparam int BIT_TRIGGER = 7;
    localparam int BIT_SMIEN   = 7;
    localparam int BIT_BANK    = 7;
    localparam int BIT_FIXCLK  = 1;
    localparam int BIT_SMRAM   = 2;
    localparam int BIT_SWFLAG  = 4;

    typedef enum logic [1:0] {
        DIV_BY4 = 2'b00,
        DIV_BY6 = 2'b01,
        DIV_BY8 = 2'b10,
        DIV_RSV = 2'b11
    } isa_div_e;

endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfgp_pkg::*;
#(
    parameter int DW       = 8,
    parameter bit EXTENDED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic          dat_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] idx_o,
    output logic [DW-1:0] rd_byte,
    output logic          wr_accept,
    output logic [DW-1:0] tap_clkdiv,
    output logic [DW-1:0] tap_clksrc,
    output logic [DW-1:0] tap_smien,
    output logic [DW-1:0] tap_smram
);

    localparam int            REG_COUNT = 1 << DW;
    localparam logic [DW-1:0] EXT_LO    = DW'(EXT_FIRST);

    typedef struct packed {
        logic [DW-1:0]                 idx;
        logic [REG_COUNT-1:0][DW-1:0]  regs;
    } rf_state_t;

    rf_state_t s_d, s_q;

    always_comb begin
        wr_accept = dat_wr && (EXTENDED || (s_q.idx < EXT_LO));
        s_d = s_q;
        if (idx_wr) begin
            s_d.idx = wdata;
        end
        if (wr_accept) begin
            s_d.regs[s_q.idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idx_o      = s_q.idx;
    assign rd_byte    = s_q.regs[s_q.idx];
    assign tap_clkdiv = s_q.regs[DW'(IDX_CLKDIV)];
    assign tap_clksrc = s_q.regs[DW'(IDX_CLKSRC)];
    assign tap_smien  = s_q.regs[DW'(IDX_SMIEN)];
    assign tap_smram  = s_q.regs[DW'(IDX_SMRAM)];

    // R1: an index-port write is the index seen on the next cycle
    p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (idx_o == $past(wdata)));

    // R3: basic variant keeps the whole array unchanged on an upper-range write
    p_basic_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !EXTENDED && (idx_o >= EXT_LO)) |=> $stable(s_q.regs));

endmodule

// File: rtl/cfg_smi_ctrl.sv
module cfg_smi_ctrl
    import cfgp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          smi_en,
    input  logic          bank_wr,
    input  logic          bank_sel,
    input  logic          rd_clr,
    input  logic          smi_ack,
    output logic [DW-1:0] stat_byte,
    output logic          smi_req
);

    typedef struct packed {
        logic [DW-1:0] st0;
        logic [DW-1:0] st1;
        logic          bank;
        logic          req;
    } smi_state_t;

    smi_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (bank_wr) begin
            s_d.bank = bank_sel;
        end
        if (rd_clr) begin
            if (s_q.bank) begin
                s_d.st1 = '0;
            end else begin
                s_d.st0 = '0;
            end
        end
        if (trig) begin
            s_d.st0[BIT_SWFLAG] = 1'b1;
        end
        if (smi_ack) begin
            s_d.req = 1'b0;
        end
        if (trig && smi_en) begin
            s_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_byte = s_q.bank ? s_q.st1 : s_q.st0;
    assign smi_req   = s_q.req;

    // R4: an enabled trigger raises the request
    p_trigger_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && smi_en) |=> smi_req);

    // R4: every trigger marks the software flag
    p_trigger_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> s_q.st0[BIT_SWFLAG]);

    // R6: the request holds until acknowledged
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req && !smi_ack) |=> smi_req);

    // R6: without a trigger the request never rises
    p_req_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!smi_req && !trig) |=> !smi_req);

    // R5: a read of the selected byte leaves it zero
    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !trig && !bank_wr) |=> (stat_byte == '0));

endmodule

// File: rtl/cfg_isaclk.sv
module cfg_isaclk
    import cfgp_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       div_sel,
    input  logic             fixed_sel,
    output logic [DIV_W-1:0] isa_div,
    output logic             isa_fixed
);

    localparam logic [DIV_W-1:0] DIV4 = DIV_W'(4);
    localparam logic [DIV_W-1:0] DIV6 = DIV_W'(6);
    localparam logic [DIV_W-1:0] DIV8 = DIV_W'(8);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             fixed;
    } clk_state_t;

    clk_state_t s_d, s_q;

    always_comb begin
        s_d.fixed = fixed_sel;
        case (isa_div_e'(div_sel))
            DIV_BY6: s_d.div = DIV6;
            DIV_BY8: s_d.div = DIV8;
            default: s_d.div = DIV4;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.div   <= DIV4;
            s_q.fixed <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign isa_div   = s_q.div;
    assign isa_fixed = s_q.fixed;

    // R7: divide-by-6 code follows one cycle later
    p_div_six_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == 2'b01) |=> (isa_div == DIV6));

    // R7: divide-by-8 code follows one cycle later
    p_div_eight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == 2'b10) |=> (isa_div == DIV8));

    // R8: fixed-clock select follows one cycle later
    p_fixed_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_sel |=> isa_fixed);

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfgp_pkg::*;
#(
    parameter bit EXTENDED = 1'b1,
    parameter int DW       = 8,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DW-1:0]     io_wdata,
    output logic [DW-1:0]     io_rdata,
    input  logic              smi_ack,
    output logic              smi_req,
    output logic [3:0]        isa_div,
    output logic              isa_fixed_clk,
    output logic              smram_win_en
);

    localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(PORT_INDEX);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(PORT_DATA);
    localparam logic [DW-1:0]     I_SWSMI = DW'(IDX_SWSMI);
    localparam logic [DW-1:0]     I_STAT  = DW'(IDX_STATUS);

    logic          idx_wr, dat_wr, dat_rd;
    logic [DW-1:0] idx, reg_byte, stat_byte;
    logic          wr_accept;
    logic [DW-1:0] tap_clkdiv, tap_clksrc, tap_smien, tap_smram;
    logic          on_status, trig, bank_wr, rd_clr;

    always_comb begin
        idx_wr    = io_wr && (io_addr == A_INDEX);
        dat_wr    = io_wr && (io_addr == A_DATA);
        dat_rd    = io_rd && (io_addr == A_DATA);
        on_status = EXTENDED && (idx == I_STAT);
        trig      = wr_accept && (idx == I_SWSMI) && io_wdata[BIT_TRIGGER];
        bank_wr   = wr_accept && (idx == I_STAT);
        rd_clr    = dat_rd && on_status;
        if (!dat_rd) begin
            io_rdata = '1;
        end else if (on_status) begin
            io_rdata = stat_byte;
        end else begin
            io_rdata = reg_byte;
        end
    end

    cfg_regfile #(
        .DW       (DW),
        .EXTENDED (EXTENDED)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr     (idx_wr),
        .dat_wr     (dat_wr),
        .wdata      (io_wdata),
        .idx_o      (idx),
        .rd_byte    (reg_byte),
        .wr_accept  (wr_accept),
        .tap_clkdiv (tap_clkdiv),
        .tap_clksrc (tap_clksrc),
        .tap_smien  (tap_smien),
        .tap_smram  (tap_smram)
    );

    cfg_smi_ctrl #(
        .DW (DW)
    ) u_smi (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .smi_en    (tap_smien[BIT_SMIEN]),
        .bank_wr   (bank_wr),
        .bank_sel  (io_wdata[BIT_BANK]),
        .rd_clr    (rd_clr),
        .smi_ack   (smi_ack),
        .stat_byte (stat_byte),
        .smi_req   (smi_req)
    );

    cfg_isaclk #(
        .DIV_W (4)
    ) u_isaclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_sel   (tap_clkdiv[1:0]),
        .fixed_sel (tap_clksrc[BIT_FIXCLK]),
        .isa_div   (isa_div),
        .isa_fixed (isa_fixed_clk)
    );

    generate
        if (EXTENDED) begin : g_smram
            assign smram_win_en = tap_smram[BIT_SMRAM];
        end else begin : g_no_smram
            assign smram_win_en = 1'b0;
        end
    endgenerate

    // R2: reads away from the data port return all ones
    p_other_port_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (io_addr != A_DATA)) |-> (io_rdata == '1));

    // R5: a status read empties the byte it returned
    p_status_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && on_status && !io_wr) |=> (stat_byte == '0));

endmodule

// File: tb/cfg_index_port_tb.sv
module cfg_index_port_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic       smi_ack = 1'b0;

    logic [7:0] rdata_e, rdata_b;
    logic       smi_e, smi_b, fix_e, fix_b, win_e, win_b;
    logic [3:0] div_e, div_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_index_port #(.EXTENDED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rdata_e), .smi_ack(smi_ack), .smi_req(smi_e),
        .isa_div(div_e), .isa_fixed_clk(fix_e), .smram_win_en(win_e)
    );

    cfg_index_port #(.EXTENDED(1'b0)) u_dut_basic (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rdata_b), .smi_ack(smi_ack), .smi_req(smi_b),
        .isa_div(div_b), .isa_fixed_clk(fix_b), .smram_win_en(win_b)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] port, input logic [7:0] data);
        @(negedge clk);
        io_addr  = port;
        io_wdata = data;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr    = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] port, output logic [7:0] re, output logic [7:0] rb);
        @(negedge clk);
        io_addr = port;
        io_rd   = 1'b1;
        #1;
        re = rdata_e;
        rb = rdata_b;
        @(negedge clk);
        io_rd   = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] index, input logic [7:0] data);
        io_write(8'h22, index);
        io_write(8'h23, data);
    endtask

    task automatic reg_read(input logic [7:0] index, output logic [7:0] re, output logic [7:0] rb);
        io_write(8'h22, index);
        io_read(8'h23, re, rb);
    endtask

    task automatic t_reset;
        logic [7:0] re, rb;
        #1;
        chk("R10 smi_req", {7'd0, smi_e}, 8'h00);
        chk("R10 isa_div", {4'd0, div_e}, 8'h04);
        chk("R10 isa_fixed_clk", {7'd0, fix_e}, 8'h00);
        chk("R10 smram_win_en", {7'd0, win_e}, 8'h00);
        reg_read(8'h10, re, rb);
        chk("R10 reg 10h", re, 8'h00);
        reg_read(8'h6A, re, rb);
        chk("R10 status byte 0", re, 8'h00);
    endtask

    task automatic t_index_data;
        logic [7:0] re, rb;
        reg_write(8'h12, 8'hA5);
        reg_write(8'h13, 8'h3C);
        reg_read(8'h12, re, rb);
        chk("R1 reg 12h ext", re, 8'hA5);
        chk("R1 reg 12h basic", rb, 8'hA5);
        reg_read(8'h13, re, rb);
        chk("R1 reg 13h", re, 8'h3C);
        reg_write(8'hFF, 8'h81);
        reg_read(8'hFF, re, rb);
        chk("R1 reg FFh ext", re, 8'h81);
    endtask

    task automatic t_other_port;
        logic [7:0] re, rb;
        io_write(8'h22, 8'h12);
        io_read(8'h22, re, rb);
        chk("R2 read index port", re, 8'hFF);
        io_read(8'h40, re, rb);
        chk("R2 read port 40h", re, 8'hFF);
        io_read(8'h23, re, rb);
        chk("R2 data port still returns reg", re, 8'hA5);
    endtask

    task automatic t_basic_and_window;
        logic [7:0] re, rb;
        reg_write(8'h61, 8'h5A);
        reg_read(8'h61, re, rb);
        chk("R3 reg 61h ext", re, 8'h5A);
        chk("R3 reg 61h basic dropped", rb, 8'h00);
        reg_write(8'h70, 8'h04);
        #1;
        chk("R9 smram window ext", {7'd0, win_e}, 8'h01);
        chk("R3 smram window basic", {7'd0, win_b}, 8'h00);
        reg_write(8'h70, 8'hFB);
        #1;
        chk("R9 smram window off", {7'd0, win_e}, 8'h00);
    endtask

    task automatic t_swsmi;
        logic [7:0] re, rb;
        reg_write(8'h65, 8'h00);
        reg_write(8'h64, 8'h80);
        #1;
        chk("R4 no req when disabled", {7'd0, smi_e}, 8'h00);
        reg_read(8'h6A, re, rb);
        chk("R4 flag set in status 0", re, 8'h10);
        chk("R3 basic status index plain reg", rb, 8'h00);
        io_read(8'h23, re, rb);
        chk("R5 status cleared by read", re, 8'h00);
        reg_write(8'h65, 8'h80);
        reg_write(8'h64, 8'h7F);
        #1;
        chk("R4 bit7 clear no req", {7'd0, smi_e}, 8'h00);
        reg_read(8'h6A, re, rb);
        chk("R4 bit7 clear no flag", re, 8'h00);
        reg_write(8'h64, 8'h80);
        #1;
        chk("R4 req raised", {7'd0, smi_e}, 8'h01);
        chk("R3 basic no req", {7'd0, smi_b}, 8'h00);
        repeat (3) @(negedge clk);
        #1;
        chk("R6 req held", {7'd0, smi_e}, 8'h01);
        @(negedge clk);
        smi_ack = 1'b1;
        @(negedge clk);
        smi_ack = 1'b0;
        #1;
        chk("R6 req cleared by ack", {7'd0, smi_e}, 8'h00);
        io_write(8'h22, 8'h64);
        smi_ack = 1'b1;
        io_write(8'h23, 8'h80);
        smi_ack = 1'b0;
        #1;
        chk("R6 trigger beats ack", {7'd0, smi_e}, 8'h01);
        @(negedge clk);
        smi_ack = 1'b1;
        @(negedge clk);
        smi_ack = 1'b0;
    endtask

    task automatic t_banks;
        logic [7:0] re, rb;
        reg_read(8'h6A, re, rb);
        chk("R5 flag from last trigger", re, 8'h10);
        reg_write(8'h64, 8'h80);
        reg_write(8'h6A, 8'h80);
        io_read(8'h23, re, rb);
        chk("R5 bank 1 read", re, 8'h00);
        io_write(8'h23, 8'h00);
        io_read(8'h23, re, rb);
        chk("R5 bank 0 untouched by bank 1 read", re, 8'h10);
        io_read(8'h23, re, rb);
        chk("R5 bank 0 cleared", re, 8'h00);
    endtask

    task automatic clk_case(input logic [7:0] v10, input logic [3:0] exp, input string tag);
        reg_write(8'h10, v10);
        @(negedge clk);
        #1;
        chk(tag, {4'd0, div_e}, {4'd0, exp});
        chk(tag, {4'd0, div_b}, {4'd0, exp});
    endtask

    task automatic t_isa_clock;
        clk_case(8'h01, 4'd6, "R7 code 01");
        clk_case(8'hFE, 4'd8, "R7 code 10");
        clk_case(8'h03, 4'd4, "R7 code 11");
        clk_case(8'h00, 4'd4, "R7 code 00");
        reg_write(8'h1C, 8'h02);
        @(negedge clk);
        #1;
        chk("R8 fixed clock on", {7'd0, fix_e}, 8'h01);
        reg_write(8'h1C, 8'hFD);
        @(negedge clk);
        #1;
        chk("R8 fixed clock off", {7'd0, fix_e}, 8'h00);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_index_data();
        t_other_port();
        t_basic_and_window();
        t_swsmi();
        t_banks();
        t_isa_clock();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule